// File: doc/BRIEF.md
# Dual-Rate Synchronized Sample Scheduler

This block paces a six-channel ADC from the system clock. A free-running period counter issues one convert request every `PERIOD` cycles (400 cycles, which is 100 kHz from a 40 MHz clock). All six channels are converted by that one request. Because the period comes from the counter alone, the time the ADC or the packing logic takes cannot lengthen the sample period.

Four channels are fast channels. Their values go out on every conversion as one 64-bit frame. The other two channels are slow channels. A decimation counter keeps only one conversion of them in every `DECIM` (100), so the slow stream runs at exactly 1/100 of the fast rate. Every kept slow sample comes from the same conversion as a fast frame.

Frames leave on a valid/ready stream that feeds a FIFO. The stream carries a tag bit that lets the far side tell slow frames from fast ones. Raising `enable` restarts both counters together, which fixes the phase of the slow stream against the fast stream. Two sticky flags report problems: a frame dropped because the stream was not ready, and a conversion that did not return before the next request.

Top module: `dual_rate_sampler`

## Requirements
- R1: While `enable` is high, `conv_req` is a one-cycle pulse that recurs exactly every PERIOD (400) cycles, whatever the ADC latency and stream state.
- R2: `conv_req` is high in the first cycle in which `enable` is high, and it is never high while `enable` is low. Lowering and raising `enable` restarts the period and decimation phases from zero.
- R3: A conversion whose `adc_valid` arrives in a cycle after its request and before the next request is accepted. In the following cycle `out_valid` is high with a fast frame: bit 64 = 0, and channel k (from `adc_data[16k+15:16k]`, k = 0..3) sits at bits [16k+15:16k].
- R4: Number the requests since `enable` rose as 0, 1, 2, ... A request keeps the slow channels only when its number mod DECIM (100) equals DECIM-1. The decimation counter resets to 0 when its value is greater than or equal to DECIM-1, and otherwise increments. No other request produces a slow frame.
- R5: A slow frame follows its fast frame in the very next cycle. It has bit 64 = 1, channel 4 at [15:0], channel 5 at [31:16], and zero at [63:32].
- R6: When a request finds its previous conversion still outstanding, `missed` is set and stays set until reset. The outstanding conversion is abandoned and the request timing does not change.
- R7: A cycle in which `out_valid` is high and `out_ready` is low drops that frame and sets `overrun`, which stays set until reset.
- R8: During and right after reset, `conv_req`, `out_valid`, `overrun` and `missed` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the scheduler. Its rising edge aligns both rates |
| conv_req | output | 1 | One-cycle request to convert all six channels |
| adc_valid | input | 1 | ADC result strobe |
| adc_data | input | 96 | Six 16-bit channel values, channel k at [16k+15:16k] |
| out_ready | input | 1 | Stream sink can take a frame |
| out_valid | output | 1 | Frame present on `out_data` |
| out_data | output | 65 | Frame: bit 64 is the slow tag, bits 63:0 the payload |
| overrun | output | 1 | Sticky: a frame was dropped |
| missed | output | 1 | Sticky: a conversion did not return in time |

## Verification
The bench measures the gap between requests across random ADC latencies of up to 300 cycles, including a stall that never returns data. A design that timed each period from the end of the previous conversion would show gaps longer than 400, and a design that re-armed after a stall would shift the phase. It stops and restarts `enable` and expects the slow frame on request 99 both times. A decimation counter that started at 1, compared with the wrong bound, or missed the restart would put the slow frame on the wrong request, or add or lose one. Each frame is compared in the exact cycle it must appear, so swapped channels, a wrong tag bit or an extra cycle of latency show up. Holding `out_ready` low and then releasing it exposes an overrun flag that is not sticky.

// File: rtl/drs_pkg.sv
package drs_pkg;
  parameter int CH_W    = 16;
  parameter int N_FAST  = 4;
  parameter int N_SLOW  = 2;
  parameter int N_CH    = N_FAST + N_SLOW;
  parameter int ADC_W   = N_CH * CH_W;
  parameter int PAY_W   = N_FAST * CH_W;
  parameter int FRAME_W = PAY_W + 1;

  // fast frame: tag 0, fast channels in ascending lanes
  function automatic logic [FRAME_W-1:0] pack_fast(input logic [ADC_W-1:0] s);
    logic [FRAME_W-1:0] f;
    f = '0;
    for (int k = 0; k < N_FAST; k++) f[k*CH_W +: CH_W] = s[k*CH_W +: CH_W];
    f[FRAME_W-1] = 1'b0;
    return f;
  endfunction

  // slow frame: tag 1, slow channels in the low lanes, rest zero
  function automatic logic [FRAME_W-1:0] pack_slow(input logic [ADC_W-1:0] s);
    logic [FRAME_W-1:0] f;
    f = '0;
    for (int k = 0; k < N_SLOW; k++) f[k*CH_W +: CH_W] = s[(N_FAST+k)*CH_W +: CH_W];
    f[FRAME_W-1] = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/drs_period_timer.sv
module drs_period_timer #(
  parameter int PERIOD = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic strobe
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!enable) cnt <= '0;
    else              cnt <= step(cnt);
  end

  assign strobe = enable && (cnt == '0);
endmodule

// File: rtl/drs_decimator.sv
module drs_decimator #(
  parameter int DECIM = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic strobe,
  output logic keep
);
  localparam int CW = $clog2(DECIM);
  localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

  logic [CW-1:0] dcnt;

  function automatic logic at_limit(input logic [CW-1:0] c);
    return c >= LAST;
  endfunction

  assign keep = strobe && at_limit(dcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcnt <= '0;
    else if (!enable) dcnt <= '0;
    else if (strobe)  dcnt <= at_limit(dcnt) ? '0 : dcnt + 1'b1;
  end
endmodule

// File: rtl/drs_conv_tracker.sv
module drs_conv_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic strobe,
  input  logic keep,
  input  logic adc_valid,
  output logic accept,
  output logic accept_slow,
  output logic missed
);
  logic pending;
  logic slow_tag;

  // a result in the same cycle as the next request counts as late
  assign accept      = pending && adc_valid && !strobe;
  assign accept_slow = accept && slow_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      slow_tag <= 1'b0;
      missed   <= 1'b0;
    end else begin
      if (!enable) begin
        pending  <= 1'b0;
        slow_tag <= 1'b0;
      end else if (strobe) begin
        pending  <= 1'b1;
        slow_tag <= keep;
      end else if (accept) begin
        pending  <= 1'b0;
      end
      if (strobe && pending) missed <= 1'b1;
    end
  end
endmodule

// File: rtl/drs_frame_packer.sv
module drs_frame_packer
  import drs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               accept_slow,
  input  logic [ADC_W-1:0]   adc_data,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [FRAME_W-1:0] out_data,
  output logic               overrun
);
  logic               slow_due;
  logic [FRAME_W-1:0] slow_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      slow_due  <= 1'b0;
      slow_buf  <= '0;
      overrun   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= pack_fast(adc_data);
        slow_due  <= accept_slow;
        slow_buf  <= pack_slow(adc_data);
      end else if (slow_due) begin
        out_valid <= 1'b1;
        out_data  <= slow_buf;
        slow_due  <= 1'b0;
      end
      if (out_valid && !out_ready) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_rate_sampler.sv
module dual_rate_sampler #(
  parameter int PERIOD = 400,
  parameter int DECIM  = 100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  output logic                         conv_req,
  input  logic                         adc_valid,
  input  logic [drs_pkg::ADC_W-1:0]    adc_data,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [drs_pkg::FRAME_W-1:0]  out_data,
  output logic                         overrun,
  output logic                         missed
);
  // named internal events
  logic strobe;
  logic keep_slow;
  logic accept;
  logic accept_slow;

  drs_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe)
  );

  drs_decimator #(.DECIM(DECIM)) u_decim (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe), .keep(keep_slow)
  );

  drs_conv_tracker u_track (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe), .keep(keep_slow),
    .adc_valid(adc_valid), .accept(accept), .accept_slow(accept_slow), .missed(missed)
  );

  drs_frame_packer u_pack (
    .clk(clk), .rst_n(rst_n), .accept(accept), .accept_slow(accept_slow),
    .adc_data(adc_data), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .overrun(overrun)
  );

  assign conv_req = strobe;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int PERIOD = 400,
  parameter int DECIM  = 100
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic conv_req,
  input logic keep_slow,
  input logic accept,
  input logic accept_slow,
  input logic out_valid,
  input logic frame_tag,
  input logic overrun,
  input logic missed
);
  localparam int GW = $clog2(PERIOD) + 1;
  localparam int DW = $clog2(DECIM) + 1;

  logic [GW-1:0] gap;
  logic          armed;
  logic [DW-1:0] since_keep;
  logic          keep_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; armed <= 1'b0; since_keep <= '0; keep_seen <= 1'b0;
    end else if (!enable) begin
      gap <= '0; armed <= 1'b0; since_keep <= '0; keep_seen <= 1'b0;
    end else begin
      if (conv_req) begin gap <= '0; armed <= 1'b1; end
      else gap <= gap + 1'b1;
      if (keep_slow) begin since_keep <= '0; keep_seen <= 1'b1; end
      else if (conv_req) since_keep <= since_keep + 1'b1;
    end
  end

  assert_strobe_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && conv_req) |-> (gap == GW'(PERIOD - 1)));
  assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  assert_start_on_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> conv_req);
  assert_gated_by_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> enable);
  assert_decim_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_seen && keep_slow) |-> (since_keep == DW'(DECIM - 1)));
  assert_keep_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    keep_slow |-> conv_req);
  assert_slow_needs_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_slow |-> accept);
  assert_slow_after_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && frame_tag) |-> ($past(out_valid) && !$past(frame_tag)));
  assert_missed_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> missed);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind dual_rate_sampler drs_checker #(.PERIOD(PERIOD), .DECIM(DECIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .conv_req(conv_req),
  .keep_slow(keep_slow), .accept(accept), .accept_slow(accept_slow),
  .out_valid(out_valid), .frame_tag(out_data[drs_pkg::FRAME_W-1]),
  .overrun(overrun), .missed(missed)
);

// File: tb/sim_dual_rate_sampler.sv
`timescale 1ns/1ps
module sim_dual_rate_sampler;
  localparam int PERIOD = 400;
  localparam int DECIM  = 100;

  logic        clk = 1'b0;
  logic        rst_n, enable, adc_valid, out_ready;
  logic [95:0] adc_data;
  logic        conv_req, out_valid, overrun, missed;
  logic [64:0] out_data;

  int n_cmp = 0, n_bad = 0;
  int strobes = 0, slow_seen = 0, idx = 0;
  bit skip_next = 1'b0;

  always #5 clk = ~clk;

  dual_rate_sampler #(.PERIOD(PERIOD), .DECIM(DECIM)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .conv_req(conv_req),
    .adc_valid(adc_valid), .adc_data(adc_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .overrun(overrun), .missed(missed)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected frames, written from the frame layout in the requirements
  function automatic logic [64:0] exp_fast(input logic [95:0] d);
    return {1'b0, d[63:48], d[47:32], d[31:16], d[15:0]};
  endfunction
  function automatic logic [64:0] exp_slow(input logic [95:0] d);
    return {1'b1, 32'h0, d[95:80], d[79:64]};
  endfunction

  // ADC model: samples 1 ns before each rising edge, drives on falling edges
  initial begin
    adc_valid = 1'b0;
    adc_data  = '0;
    forever begin
      @(negedge clk); #4;
      if (!enable) idx = 0;
      if (conv_req) begin
        bit slow;
        slow = ((idx % DECIM) == DECIM - 1);
        idx++;
        strobes++;
        if (skip_next) skip_next = 1'b0;
        else begin
          int lat;
          logic [95:0] d;
          lat = 1 + int'($urandom % 300);
          if (strobes % 7 == 0) lat = 1;
          if (strobes % 11 == 0) lat = 300;
          d = {$urandom, $urandom, $urandom};
          repeat (lat) @(negedge clk);
          adc_data = d; adc_valid = 1'b1;
          @(negedge clk);
          adc_valid = 1'b0;
          #4;
          chk(out_valid == 1'b1, "R3 fast valid", 96'(out_valid), 96'd1);
          chk(out_data == exp_fast(d), "R3 fast frame", 96'(out_data), 96'(exp_fast(d)));
          @(negedge clk); #4;
          if (slow) begin
            chk(out_valid == 1'b1, "R5 slow valid", 96'(out_valid), 96'd1);
            chk(out_data == exp_slow(d), "R5 slow frame", 96'(out_data), 96'(exp_slow(d)));
            slow_seen++;
          end else begin
            chk(out_valid == 1'b0, "R4 no slow frame", 96'(out_valid), 96'd0);
          end
        end
      end
    end
  end

  // request timing monitor
  initial begin
    int cyc, last;
    bit armed, prev_en;
    cyc = 0; last = 0; armed = 0; prev_en = 0;
    forever begin
      @(negedge clk); #4;
      cyc++;
      if (!enable) begin
        armed = 0;
        if (rst_n) chk(conv_req == 1'b0, "R2 idle no request", 96'(conv_req), 96'd0);
      end else begin
        if (!prev_en) chk(conv_req == 1'b1, "R2 request on enable", 96'(conv_req), 96'd1);
        if (conv_req) begin
          if (armed) chk(cyc - last == PERIOD, "R1 period", 96'(cyc - last), 96'(PERIOD));
          armed = 1; last = cyc;
        end
      end
      prev_en = enable;
    end
  end

  task automatic wait_strobes(input int n);
    int target;
    target = strobes + n;
    while (strobes < target) @(negedge clk);
    repeat (350) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; enable = 1'b0; out_ready = 1'b1;
    repeat (5) @(negedge clk);
    #4;
    chk(conv_req == 0, "R8 reset conv_req", 96'(conv_req), 0);
    chk(out_valid == 0, "R8 reset out_valid", 96'(out_valid), 0);
    chk(overrun == 0, "R8 reset overrun", 96'(overrun), 0);
    chk(missed == 0, "R8 reset missed", 96'(missed), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // random ADC latencies, two slow frames expected (requests 99 and 199)
    enable = 1'b1;
    wait_strobes(205);
    chk(slow_seen == 2, "R4 slow count run 1", 96'(slow_seen), 96'd2);
    chk(overrun == 0, "R7 no overrun", 96'(overrun), 0);
    chk(missed == 0, "R6 no miss", 96'(missed), 0);

    // restart: the phase of the slow stream realigns to the new start
    enable = 1'b0;
    repeat (50) @(negedge clk);
    enable = 1'b1;
    wait_strobes(101);
    chk(slow_seen == 3, "R4 slow count after restart", 96'(slow_seen), 96'd3);

    // stalled conversion (request 101, not a slow one)
    skip_next = 1'b1;
    wait_strobes(1);
    chk(missed == 0, "R6 not yet missed", 96'(missed), 0);
    wait_strobes(1);
    chk(missed == 1, "R6 missed set", 96'(missed), 96'd1);

    // sink not ready: frame dropped, flag sticks
    out_ready = 1'b0;
    wait_strobes(1);
    chk(overrun == 1, "R7 overrun set", 96'(overrun), 96'd1);
    out_ready = 1'b1;
    wait_strobes(1);
    chk(overrun == 1, "R7 overrun sticky", 96'(overrun), 96'd1);
    chk(missed == 1, "R6 missed sticky", 96'(missed), 96'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule